// File: doc/BRIEF.md
# Pixel Output Formatter with Clamping

This block sits between an incoming three-channel pixel stream (RGB, or YCbCr carried as Cr/Y/Cb) and a parallel output bus. It first optionally exchanges the red and blue inputs, then rearranges the three channels into one of six orders. Each reordered sample is clamped into a programmable window: the middle slot is treated as luma, the two outer slots as chroma. The last stage scales every sample to the selected output depth and lays the samples out on the bus. The layout is either three plain fields, or a luma/chroma pair in one of four interleave orders. When 4:2:2 output is enabled, the chroma sample alternates between Cb and Cr from pixel to pixel.

Sync and data-enable signals travel through a delay line that matches the three register stages of the pixel path, so they leave aligned with their pixel. All settings are static inputs. They are meant to be changed only while the stream is idle.

Top module: `pix_out_fmt`

## Requirements
- R1: When `rb_swap_i` is 1, the red field (`pix_i` top CW bits) and blue field (`pix_i` low CW bits) exchange places before reordering; green (middle CW bits) is unaffected.
- R2: `order_i` places the three input channels into bus slots {slot2,slot1,slot0}: 0 gives {R,G,B}, 1 gives {G,B,R}, 2 gives {B,R,G}, 3 gives {R,B,G}, 4 gives {G,R,B}, 5 gives {B,G,R}.
- R3: `order_i` codes 6 and 7 behave as code 0.
- R4: After reordering, slot1 (luma) is forced to `y_lo_i` when below it, otherwise to `y_hi_i` when above it, otherwise passed unchanged.
- R5: Slots 0 and 2 (chroma) are clamped the same way against `c_lo_i` and `c_hi_i`.
- R6: `depth_i` 0/1/2/3 selects 8/10/12/16 output bits. Each CW-bit sample v becomes floor(v·2^D / 2^CW), right-aligned in an OW-bit field, with the bits above D zero.
- R7: `ycmap_i` 7 puts {0, Y, C} on the bus as {field2, field1, field0}, 6 puts {0, C, Y}, and 0 (and codes 1 to 3) puts the three clamped slots {slot2, slot1, slot0}. Here Y is slot1. C is slot0 when 4:2:2 is off.
- R8: `ycmap_i` 5 emits {0,Y,C} on even-phase pixels and {0,C,Y} on odd-phase pixels; `ycmap_i` 4 does the opposite.
- R9: The pixel phase is even on the first active pixel (data enable high) after any inactive cycle and toggles on each further active pixel. With `en422_i` set, C is slot0 (Cb) on even phase and slot2 (Cr) on odd phase.
- R10: Pixel data, hsync, vsync and data enable each appear at the outputs exactly three clock cycles after they are presented.
- R11: While reset is asserted, `bus_o`, `hs_o`, `vs_o` and `de_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 3*CW | Input pixel {R,G,B} (or {Cr,Y,Cb}) |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| rb_swap_i | input | 1 | Exchange red and blue inputs |
| order_i | input | 3 | Channel order code |
| en422_i | input | 1 | Alternate Cb/Cr as the chroma sample |
| ycmap_i | input | 3 | Bus layout / Y-C interleave code |
| depth_i | input | 2 | Output depth code |
| y_lo_i | input | CW | Luma lower limit |
| y_hi_i | input | CW | Luma upper limit |
| c_lo_i | input | CW | Chroma lower limit |
| c_hi_i | input | CW | Chroma upper limit |
| bus_o | output | 3*OW | Formatted output bus, three OW-bit fields |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
The bench builds the block with its defaults: CW = 12 and OW = 16. With these values the 8- and 10-bit depths exercise down-scaling, 12 bits is an identity, and 16 bits exercises up-scaling into the full field width, so both shift directions of the depth logic are covered. The 12-bit limits let the boundary values one below and one above each limit reach the clamps directly. A 16-bit field leaves spare upper bits whose zero state at 8-bit depth can be observed.

// File: rtl/pof_pkg.sv
package pof_pkg;
   typedef enum logic [2:0] {
      ORD_RGB = 3'd0, ORD_GBR = 3'd1, ORD_BRG = 3'd2,
      ORD_RBG = 3'd3, ORD_GRB = 3'd4, ORD_BGR = 3'd5
   } ord_e;

   typedef enum logic [2:0] {
      YCM_RGB = 3'd0, YCM_CYCY = 3'd4, YCM_YCYC = 3'd5,
      YCM_CY = 3'd6, YCM_YC = 3'd7
   } ycm_e;

   // output depth in bits for a depth code
   function automatic int dep_bits(logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 10;
         2'd2:    return 12;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/pof_reorder.sv
module pof_reorder
   import pof_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3*CW-1:0] pix_i,
   input  logic            swap_i,
   input  logic [2:0]      order_i,
   output logic [3*CW-1:0] slots_o
);
   logic [CW-1:0]   red, grn, blu;
   logic [3*CW-1:0] slots_d;

   // R1: input exchange, R2/R3: permutation
   always_comb begin
      red = swap_i ? pix_i[CW-1:0] : pix_i[3*CW-1:2*CW];
      blu = swap_i ? pix_i[3*CW-1:2*CW] : pix_i[CW-1:0];
      grn = pix_i[2*CW-1:CW];
      case (ord_e'(order_i))
         ORD_GBR: slots_d = {grn, blu, red};
         ORD_BRG: slots_d = {blu, red, grn};
         ORD_RBG: slots_d = {red, blu, grn};
         ORD_GRB: slots_d = {grn, red, blu};
         ORD_BGR: slots_d = {blu, grn, red};
         default: slots_d = {red, grn, blu};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots_o <= '0;
      else        slots_o <= slots_d;
   end
endmodule

// File: rtl/pof_clamp.sv
module pof_clamp #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] d_i,
   input  logic [CW-1:0] lo_i,
   input  logic [CW-1:0] hi_i,
   output logic [CW-1:0] q_o
);
   logic [CW-1:0] q_d;

   always_comb begin
      if (d_i < lo_i)      q_d = lo_i;
      else if (d_i > hi_i) q_d = hi_i;
      else                 q_d = d_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_d;
   end

   // R4, R5
   clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o >= $past(lo_i)) || ($past(lo_i) > $past(hi_i))));

   // R4, R5
   clamp_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o <= $past(hi_i)) || ($past(d_i) < $past(lo_i))));

   // R4, R5
   clamp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((d_i >= lo_i) && (d_i <= hi_i)) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/pof_pack.sv
module pof_pack
   import pof_pkg::*;
#(
   parameter int CW = 12,
   parameter int OW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3*CW-1:0] slots_i,
   input  logic            de_i,
   input  logic            en422_i,
   input  logic [2:0]      ycmap_i,
   input  logic [1:0]      depth_i,
   output logic [3*OW-1:0] bus_o
);
   localparam logic [OW-1:0] ZERO_F = '0;

   logic            chroma_odd;
   logic [CW-1:0]   s0, s1, s2, y_s, c_s;
   logic [OW-1:0]   f0, f1, f2, fy, fc;
   logic [3*OW-1:0] bus_d;

   // R6: scale a sample to the selected depth, right-aligned
   function automatic logic [OW-1:0] scale(logic [CW-1:0] v, logic [1:0] code);
      int            nb;
      logic [OW-1:0] w;
      nb = dep_bits(code);
      w  = OW'(v);
      if (nb <= CW) return w >> (CW - nb);
      else          return w << (nb - CW);
   endfunction

   always_comb begin
      s0  = slots_i[CW-1:0];
      s1  = slots_i[2*CW-1:CW];
      s2  = slots_i[3*CW-1:2*CW];
      y_s = s1;
      // R9: Cb on even phase, Cr on odd phase
      c_s = (en422_i && chroma_odd) ? s2 : s0;
      f0  = scale(s0, depth_i);
      f1  = scale(s1, depth_i);
      f2  = scale(s2, depth_i);
      fy  = scale(y_s, depth_i);
      fc  = scale(c_s, depth_i);
      // R7, R8
      case (ycm_e'(ycmap_i))
         YCM_YC:   bus_d = {ZERO_F, fy, fc};
         YCM_CY:   bus_d = {ZERO_F, fc, fy};
         YCM_YCYC: bus_d = chroma_odd ? {ZERO_F, fc, fy} : {ZERO_F, fy, fc};
         YCM_CYCY: bus_d = chroma_odd ? {ZERO_F, fy, fc} : {ZERO_F, fc, fy};
         default:  bus_d = {f2, f1, f0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_o      <= '0;
         chroma_odd <= 1'b0;
      end else begin
         bus_o      <= bus_d;
         chroma_odd <= de_i ? ~chroma_odd : 1'b0;
      end
   end

   // R9
   first_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de_i && !$past(de_i)) |-> !chroma_odd);

   // R9
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de_i && $past(de_i)) |-> (chroma_odd != $past(chroma_odd)));

   // R6
   depth8_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_i == 2'd0) |=> ((bus_o[OW-1:8] == '0) &&
                             (bus_o[2*OW-1:OW+8] == '0) &&
                             (bus_o[3*OW-1:2*OW+8] == '0)));
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int CW = 12,
   parameter int OW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3*CW-1:0] pix_i,
   input  logic            hs_i,
   input  logic            vs_i,
   input  logic            de_i,
   input  logic            rb_swap_i,
   input  logic [2:0]      order_i,
   input  logic            en422_i,
   input  logic [2:0]      ycmap_i,
   input  logic [1:0]      depth_i,
   input  logic [CW-1:0]   y_lo_i,
   input  logic [CW-1:0]   y_hi_i,
   input  logic [CW-1:0]   c_lo_i,
   input  logic [CW-1:0]   c_hi_i,
   output logic [3*OW-1:0] bus_o,
   output logic            hs_o,
   output logic            vs_o,
   output logic            de_o
);
   localparam int LAT  = 3;
   localparam int SYNW = 3;

   if (OW < 16) begin : g_ow_chk
      $error("OW must be at least 16 to hold the widest depth");
   end
   if ((CW < 8) || (CW > OW)) begin : g_cw_chk
      $error("CW must lie between 8 and OW");
   end

   logic [3*CW-1:0]     ord_slots, clp_slots;
   logic [LAT*SYNW-1:0] sync_q;
   logic [1:0]          live_cnt;

   pof_reorder #(.CW(CW)) u_reorder (
      .clk     (clk),
      .rst_n   (rst_n),
      .pix_i   (pix_i),
      .swap_i  (rb_swap_i),
      .order_i (order_i),
      .slots_o (ord_slots)
   );

   // R4 on slot1, R5 on slots 0 and 2
   for (genvar i = 0; i < 3; i++) begin : g_clamp
      localparam bit IS_LUMA = (i == 1);
      pof_clamp #(.CW(CW)) u_clamp (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (ord_slots[i*CW +: CW]),
         .lo_i  (IS_LUMA ? y_lo_i : c_lo_i),
         .hi_i  (IS_LUMA ? y_hi_i : c_hi_i),
         .q_o   (clp_slots[i*CW +: CW])
      );
   end

   pof_pack #(.CW(CW), .OW(OW)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .slots_i (clp_slots),
      .de_i    (sync_q[SYNW*1]),
      .en422_i (en422_i),
      .ycmap_i (ycmap_i),
      .depth_i (depth_i),
      .bus_o   (bus_o)
   );

   // R10: timing delay line matched to the three pixel stages
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[(LAT-1)*SYNW-1:0], hs_i, vs_i, de_i};
   end
   assign {hs_o, vs_o, de_o} = sync_q[LAT*SYNW-1:(LAT-1)*SYNW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   // R10
   sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt == 2'd3) |-> ({hs_o, vs_o, de_o} == $past({hs_i, vs_i, de_i}, 3)));

   // R11
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |-> ((bus_o == '0) && !hs_o && !vs_o && !de_o));
endmodule

// File: tb/pix_out_fmt_tb_top.sv
`timescale 1ns/1ps
module pix_out_fmt_tb_top;
   localparam int CW = 12;
   localparam int OW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic [3*CW-1:0] pix_i;
   logic hs_i, vs_i, de_i, rb_swap_i, en422_i;
   logic [2:0] order_i, ycmap_i;
   logic [1:0] depth_i;
   logic [CW-1:0] y_lo_i, y_hi_i, c_lo_i, c_hi_i;
   logic [3*OW-1:0] bus_o;
   logic hs_o, vs_o, de_o;

   pix_out_fmt #(.CW(CW), .OW(OW)) dut_i (.*);

   int n_chk = 0, n_fail = 0;
   logic [3*OW-1:0] exp_bus [3];
   logic [2:0]      exp_syn [3];
   logic            exp_on  [3];
   string           exp_tag [3];
   logic            mph = 1'b0;
   int              seed_dummy;

   function automatic logic [CW-1:0] clampv(logic [CW-1:0] v, logic [CW-1:0] lo, logic [CW-1:0] hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic logic [OW-1:0] depthv(logic [CW-1:0] v, logic [1:0] dc);
      int nb;
      longint x;
      nb = (dc == 0) ? 8 : (dc == 1) ? 10 : (dc == 2) ? 12 : 16;
      x = (longint'(v) * (longint'(1) << nb)) / (longint'(1) << CW);
      return OW'(x);
   endfunction

   function automatic logic [3*OW-1:0] fmt_model(logic [3*CW-1:0] p, logic ph);
      logic [CW-1:0] r, g, b, t, a2, a1, a0, yy, cc;
      logic [OW-1:0] zf;
      zf = '0;
      r = p[3*CW-1:2*CW]; g = p[2*CW-1:CW]; b = p[CW-1:0];
      if (rb_swap_i) begin t = r; r = b; b = t; end
      case (order_i)
         3'd1:    begin a2 = g; a1 = b; a0 = r; end
         3'd2:    begin a2 = b; a1 = r; a0 = g; end
         3'd3:    begin a2 = r; a1 = b; a0 = g; end
         3'd4:    begin a2 = g; a1 = r; a0 = b; end
         3'd5:    begin a2 = b; a1 = g; a0 = r; end
         default: begin a2 = r; a1 = g; a0 = b; end
      endcase
      a1 = clampv(a1, y_lo_i, y_hi_i);
      a0 = clampv(a0, c_lo_i, c_hi_i);
      a2 = clampv(a2, c_lo_i, c_hi_i);
      yy = a1;
      cc = (en422_i && ph) ? a2 : a0;
      case (ycmap_i)
         3'd7: return {zf, depthv(yy, depth_i), depthv(cc, depth_i)};
         3'd6: return {zf, depthv(cc, depth_i), depthv(yy, depth_i)};
         3'd5: return ph ? {zf, depthv(cc, depth_i), depthv(yy, depth_i)}
                         : {zf, depthv(yy, depth_i), depthv(cc, depth_i)};
         3'd4: return ph ? {zf, depthv(yy, depth_i), depthv(cc, depth_i)}
                         : {zf, depthv(cc, depth_i), depthv(yy, depth_i)};
         default: return {depthv(a2, depth_i), depthv(a1, depth_i), depthv(a0, depth_i)};
      endcase
   endfunction

   task automatic step(input logic [3*CW-1:0] p, input logic h, input logic v,
                       input logic d, input logic chk, input string tag);
      @(negedge clk);
      if (exp_on[2]) begin
         n_chk++;
         if (bus_o !== exp_bus[2]) begin
            n_fail++;
            $display("FAIL %s bus got %h expected %h", exp_tag[2], bus_o, exp_bus[2]);
         end
         n_chk++;
         if ({hs_o, vs_o, de_o} !== exp_syn[2]) begin
            n_fail++;
            $display("FAIL R10 sync got %b expected %b", {hs_o, vs_o, de_o}, exp_syn[2]);
         end
      end
      for (int k = 2; k > 0; k--) begin
         exp_bus[k] = exp_bus[k-1]; exp_syn[k] = exp_syn[k-1];
         exp_on[k] = exp_on[k-1];   exp_tag[k] = exp_tag[k-1];
      end
      exp_bus[0] = fmt_model(p, mph);
      exp_syn[0] = {h, v, d};
      exp_on[0]  = chk;
      exp_tag[0] = tag;
      mph = d ? ~mph : 1'b0;
      pix_i = p; hs_i = h; vs_i = v; de_i = d;
   endtask

   task automatic drain();
      for (int k = 0; k < 4; k++) step('0, 1'b0, 1'b0, 1'b0, 1'b0, "");
   endtask

   task automatic cfg(input logic sw, input logic [2:0] ord, input logic e422,
                      input logic [2:0] map, input logic [1:0] dep,
                      input logic [CW-1:0] ylo, input logic [CW-1:0] yhi,
                      input logic [CW-1:0] clo, input logic [CW-1:0] chi);
      drain();
      rb_swap_i = sw; order_i = ord; en422_i = e422; ycmap_i = map; depth_i = dep;
      y_lo_i = ylo; y_hi_i = yhi; c_lo_i = clo; c_hi_i = chi;
   endtask

   task automatic line(input int n, input string tag);
      for (int k = 0; k < n; k++)
         step(3*CW'({$urandom, $urandom}), 1'($urandom), 1'($urandom), 1'b1, 1'b1, tag);
      step(3*CW'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b1, tag);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8ns * 200000);
      n_fail++;
      $display("FAIL R10 watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      logic [CW-1:0] edge_v [11];
      seed_dummy = $urandom(24680);
      edge_v = '{12'h000, 12'h00F, 12'h010, 12'h011, 12'h03F, 12'h040,
                 12'hF00, 12'hF01, 12'hFE0, 12'hFE1, 12'hFFF};
      for (int k = 0; k < 3; k++) begin exp_on[k] = 1'b0; exp_tag[k] = ""; end
      rst_n = 1'b0; pix_i = '1; hs_i = 1'b1; vs_i = 1'b1; de_i = 1'b1;
      rb_swap_i = 0; order_i = 0; en422_i = 0; ycmap_i = 0; depth_i = 2;
      y_lo_i = 0; y_hi_i = '1; c_lo_i = 0; c_hi_i = '1;
      repeat (3) @(negedge clk);
      n_chk++;
      if (bus_o !== '0 || hs_o !== 1'b0 || vs_o !== 1'b0 || de_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R11 reset outputs got %h/%b expected 0", bus_o, {hs_o, vs_o, de_o});
      end
      pix_i = '0; hs_i = 0; vs_i = 0; de_i = 0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1, R2, R3: every order code with and without the red/blue exchange
      for (int o = 0; o < 8; o++)
         for (int s = 0; s < 2; s++) begin
            cfg(1'(s), 3'(o), 0, 0, 2, 0, '1, 0, '1);
            line(5, (o > 5) ? "R3" : (s == 1) ? "R1" : "R2");
         end

      // R4, R5: boundary values around distinct luma and chroma windows
      for (int s = 0; s < 2; s++) begin
         cfg(0, 3'(s * 5), 0, 0, 2, 12'h040, 12'hF00, 12'h010, 12'hFE0);
         for (int a = 0; a < 11; a++)
            step({edge_v[a], edge_v[a], edge_v[10-a]}, 0, 0, 1, 1, "R4 R5");
      end
      cfg(0, 0, 0, 0, 2, 12'h800, 12'h700, 12'h800, 12'h700);
      for (int a = 0; a < 11; a++) step({3{edge_v[a]}}, 0, 0, 1, 1, "R4 R5");

      // R6: each output depth, with boundary codes
      for (int d = 0; d < 4; d++) begin
         cfg(0, 0, 0, 0, 2'(d), 0, '1, 0, '1);
         step({12'hFFF, 12'h000, 12'h00F}, 0, 0, 1, 1, "R6");
         step({12'h801, 12'h7FF, 12'h010}, 0, 0, 1, 1, "R6");
         line(6, "R6");
      end

      // R7, R8: every map code with 4:2:2 off, lines separated by idle cycles
      for (int m = 0; m < 8; m++) begin
         cfg(0, 0, 0, 3'(m), 2, 0, '1, 0, '1);
         line(5, (m >= 4) ? "R8" : "R7");
         line(2, (m >= 4) ? "R8" : "R7");
      end

      // R9: chroma alternation, single-pixel and odd-length lines
      for (int m = 4; m < 8; m++) begin
         cfg(1, 0, 1, 3'(m), 2, 0, '1, 0, '1);
         line(1, "R9");
         line(7, "R9");
         line(4, "R9");
      end

      // mixed random configurations and streams
      for (int r = 0; r < 60; r++) begin
         cfg(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom), 2'($urandom),
             CW'($urandom_range(0, 255)), CW'($urandom_range(3840, 4095)),
             CW'($urandom), CW'($urandom));
         for (int l = 0; l < 4; l++) line($urandom_range(1, 9), "R7 R9 R4 R5");
      end
      drain();
      finish_run();
   end
endmodule